// File: doc/BRIEF.md
# Programmable OR-Input Flip-Flop Array

This block is a grid of identical D flip-flop cells. Each cell has a true and an inverted output, and both can be selected as inputs by any cell. A crosspoint store holds one enable bit for every combination of target cell, source signal and polarity. On each clock edge, a cell loads the OR of the signals its enabled crosspoints select. The sources are all cell outputs plus a set of external stream inputs. Each stream input is meant to feed the first cell of one row.

Software fills the crosspoint store in program mode, one bit per write, through an address and data port. The flip-flops are frozen during this time. When program mode ends, every flip-flop is cleared once, and then the array evaluates on every edge. Two uses follow from this:

- A row of cells, each taking the true output of its left neighbour, forms a shift pipeline.
- A cell that takes complemented pattern bits for positions that must be 1, and true bits for positions that must be 0, is a one-cycle ternary matcher. Its inverted output signals a match, and positions without a crosspoint are don't-care.

Top module: `orfab_fabric`

## Requirements
- R1: A synchronous active-low reset clears every flip-flop (q_o all 0) and every crosspoint bit (each reads back 0).
- R2: A write with cfg_we=1 in program mode stores cfg_wdata into the crosspoint that cfg_tgt, cfg_src and cfg_pol address, and cfg_rdata returns it combinationally. Source indices run as follows: 0..NCELL-1 are cells (cell = row*COLS+col), and NCELL+k is stream input k. Polarity 0 selects the true output and 1 the inverted one. A source index of NSRC or above is neither stored nor read (reads 0).
- R3: A write issued while prog_en=0 changes no crosspoint and does not alter the outputs.
- R4: While prog_en=1, every flip-flop keeps its value whatever the stream inputs do.
- R5: The first rising edge with prog_en=0 after a program period loads 0 into every flip-flop. Evaluation starts on the following edge.
- R6: In run mode, each cell loads, at each rising edge, the OR of all source literals whose crosspoint is set.
- R7: A cell with no crosspoint set loads 0.
- R8: A cell programmed with the inverted outputs of several sources presents their AND on qn_o one edge after the sources settle.
- R9: A row wired stream-to-column-0, then each column to its left neighbour's true output, shifts the stream one column per edge.
- R10: A matcher cell presents mismatch on q_o and match on qn_o one edge after the compared cells hold the pattern. Matching ignores the don't-care positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | 1 = program mode (flops frozen), 0 = run mode |
| cfg_we | input | 1 | Crosspoint write strobe, honoured only in program mode |
| cfg_tgt | input | TW (4) | Target cell index |
| cfg_src | input | SW (5) | Source index: cells first, then stream inputs |
| cfg_pol | input | 1 | 0 = true output, 1 = inverted output |
| cfg_wdata | input | 1 | Crosspoint value to write |
| cfg_rdata | output | 1 | Crosspoint value at the current address |
| stream_i | input | NSTREAM (4) | External stream inputs |
| q_o | output | NCELL (16) | True outputs of all cells |
| qn_o | output | NCELL (16) | Inverted outputs of all cells |

## Verification
Every flip-flop result is due at the first rising edge after its inputs are driven. The bench changes inputs on the falling edge and compares outputs on the next falling edge, against a model stepped once per edge. Readback has no register, so it is compared a moment after the address changes. The clear on leaving program mode is checked at the falling edge after the first run edge. A matcher or AND result is checked one edge after the cells it compares have been updated, which is exactly when the stepped model produces it.

// File: rtl/orfab_pkg.sv
// Shared definitions for the OR-input flip-flop array.
// Assumes nothing beyond standard SystemVerilog.
package orfab_pkg;
    // Polarity of a crosspoint literal.
    typedef enum logic {
        LIT_TRUE = 1'b0,
        LIT_COMP = 1'b1
    } lit_pol_e;

    // Index width that stays at least one bit for tiny arrays.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/orfab_mode_ctrl.sv
// Mode controller: turns the program-mode level into a freeze signal and a
// single-cycle clear pulse on the first run edge after a program period.
// Assumes prog_en is synchronous to clk.
module orfab_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    output logic hold,
    output logic clr
);
    logic prog_q;

    // Remember whether the previous edge was in program mode.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= 1'b0;
        else        prog_q <= prog_en;
    end

    assign hold = prog_en;
    assign clr  = !prog_en && prog_q;

    // R5: the clear lasts exactly one edge.
    p_clear_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clr);
endmodule

// File: rtl/orfab_xbar.sv
// Crosspoint store and wired-OR evaluation. Holds one enable bit per
// (target, source, polarity), accepts single-bit writes only in program mode,
// returns the addressed bit combinationally, and forms each target's OR.
// Assumes src_vec carries cell outputs first, then stream inputs.
module orfab_xbar
    import orfab_pkg::*;
#(
    parameter int unsigned NCELL = 16,
    parameter int unsigned NSRC  = 20,
    parameter int unsigned TW    = 4,
    parameter int unsigned SW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic             cfg_we,
    input  logic [TW-1:0]    cfg_tgt,
    input  logic [SW-1:0]    cfg_src,
    input  logic             cfg_pol,
    input  logic             cfg_wdata,
    output logic             cfg_rdata,
    input  logic [NSRC-1:0]  src_vec,
    output logic [NCELL-1:0] d_vec
);
    logic [NCELL-1:0][NSRC-1:0] cfg_t;
    logic [NCELL-1:0][NSRC-1:0] cfg_c;
    logic addr_ok;
    logic wr_ok;

    // Address is valid when both indices fall inside the array.
    assign addr_ok = (int'(cfg_tgt) < int'(NCELL)) && (int'(cfg_src) < int'(NSRC));
    assign wr_ok   = prog_en && cfg_we && addr_ok;

    // Store one crosspoint bit per write; reset clears the whole store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_t <= '0;
            cfg_c <= '0;
        end else if (wr_ok) begin
            if (cfg_pol == LIT_COMP) cfg_c[cfg_tgt][cfg_src] <= cfg_wdata;
            else                     cfg_t[cfg_tgt][cfg_src] <= cfg_wdata;
        end
    end

    // Readback of the addressed crosspoint, zero outside the array.
    always_comb begin
        cfg_rdata = 1'b0;
        if (addr_ok) begin
            cfg_rdata = (cfg_pol == LIT_COMP) ? cfg_c[cfg_tgt][cfg_src]
                                              : cfg_t[cfg_tgt][cfg_src];
        end
    end

    // One OR per target over its enabled true and inverted literals.
    for (genvar t = 0; t < NCELL; t++) begin : g_eval
        assign d_vec[t] = (|(cfg_t[t] & src_vec)) | (|(cfg_c[t] & ~src_vec));
    end

    // R3: the store does not move outside program mode.
    p_store_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> ($stable(cfg_t) && $stable(cfg_c)));

    // R2: an accepted write lands at its address.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> ((($past(cfg_pol) == LIT_COMP)
                    ? cfg_c[$past(cfg_tgt)][$past(cfg_src)]
                    : cfg_t[$past(cfg_tgt)][$past(cfg_src)]) == $past(cfg_wdata)));
endmodule

// File: rtl/orfab_cell.sv
// One array cell: a D flip-flop that is frozen in program mode, cleared by
// the exit pulse, and otherwise loads its evaluated OR.
// Assumes hold and clr are never both high.
module orfab_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic clr,
    input  logic d,
    output logic q
);
    // State update with priority reset, freeze, clear, evaluate.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (hold)   q <= q;
        else if (clr)    q <= 1'b0;
        else             q <= d;
    end

    // R4: frozen during program mode.
    p_hold_in_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q));

    // R5: the exit pulse leaves the cell at 0.
    p_clear_on_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);
endmodule

// File: rtl/orfab_fabric.sv
// Top of the OR-input flip-flop array: ROWS x COLS cells, a crosspoint store
// and a mode controller. Sources are all cell outputs followed by NSTREAM
// external stream inputs; each may be taken true or inverted.
// Assumes all inputs are synchronous to clk.
module orfab_fabric
    import orfab_pkg::*;
#(
    parameter int unsigned ROWS    = 4,
    parameter int unsigned COLS    = 4,
    parameter int unsigned NSTREAM = 4,
    localparam int unsigned NCELL  = ROWS * COLS,
    localparam int unsigned NSRC   = NCELL + NSTREAM,
    localparam int unsigned TW     = idx_w(NCELL),
    localparam int unsigned SW     = idx_w(NSRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_en,
    input  logic               cfg_we,
    input  logic [TW-1:0]      cfg_tgt,
    input  logic [SW-1:0]      cfg_src,
    input  logic               cfg_pol,
    input  logic               cfg_wdata,
    output logic               cfg_rdata,
    input  logic [NSTREAM-1:0] stream_i,
    output logic [NCELL-1:0]   q_o,
    output logic [NCELL-1:0]   qn_o
);
    logic [NCELL-1:0] q_vec;
    logic [NCELL-1:0] d_vec;
    logic [NSRC-1:0]  src_vec;
    logic             hold;
    logic             clr_now;

    assign src_vec = {stream_i, q_vec};

    orfab_mode_ctrl u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_en (prog_en),
        .hold    (hold),
        .clr     (clr_now)
    );

    orfab_xbar #(
        .NCELL (NCELL),
        .NSRC  (NSRC),
        .TW    (TW),
        .SW    (SW)
    ) u_xbar (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .cfg_we    (cfg_we),
        .cfg_tgt   (cfg_tgt),
        .cfg_src   (cfg_src),
        .cfg_pol   (cfg_pol),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .src_vec   (src_vec),
        .d_vec     (d_vec)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        orfab_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .hold  (hold),
            .clr   (clr_now),
            .d     (d_vec[i]),
            .q     (q_vec[i])
        );
    end

    assign q_o  = q_vec;
    assign qn_o = ~q_vec;

    // R6: in steady run mode every cell takes its evaluated OR.
    p_eval_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_en && !clr_now) |=> (q_vec == $past(d_vec)));
endmodule

// File: tb/orfab_fabric_test.sv
// Self-checking bench for orfab_fabric with the default 4x4 array.
module orfab_fabric_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        prog_en;
    logic        cfg_we;
    logic [3:0]  cfg_tgt;
    logic [4:0]  cfg_src;
    logic        cfg_pol;
    logic        cfg_wdata;
    logic        cfg_rdata;
    logic [3:0]  stream_i;
    logic [15:0] q_o;
    logic [15:0] qn_o;

    int total = 0;
    int fails = 0;
    logic [15:0] exp_q;

    localparam logic [3:0] STIM [16] = '{4'h7, 4'hD, 4'h8, 4'h5, 4'hB, 4'h2, 4'hF, 4'h6,
                                         4'h0, 4'h9, 4'hD, 4'h2, 4'h4, 4'hF, 4'hB, 4'hE};

    always #4 clk = ~clk;

    orfab_fabric uut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_we(cfg_we),
        .cfg_tgt(cfg_tgt), .cfg_src(cfg_src), .cfg_pol(cfg_pol),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stream_i(stream_i),
        .q_o(q_o), .qn_o(qn_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Program written below: rows 0 and 2 shift, cell 4 matches 1,0,X,1 on
    // cells 0..3, cell 5 NANDs cells 8,9, cell 7 copies stream 1, cell 12
    // takes its own inverted output, everything else is empty.
    function automatic logic [15:0] model(input logic [15:0] c, input logic [3:0] s);
        logic [15:0] n = '0;
        n[0]  = s[0];  n[1]  = c[0]; n[2]  = c[1]; n[3]  = c[2];
        n[8]  = s[2];  n[9]  = c[8]; n[10] = c[9]; n[11] = c[10];
        n[4]  = !(c[0] && !c[1] && c[3]);
        n[5]  = !(c[8] && c[9]);
        n[7]  = s[1];
        n[12] = !c[12];
        return n;
    endfunction

    task automatic wr(input logic [3:0] t, input logic [4:0] s, input logic p, input logic v);
        cfg_tgt = t; cfg_src = s; cfg_pol = p; cfg_wdata = v; cfg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] t, input logic [4:0] s, input logic p,
                      input logic e, input string req);
        cfg_tgt = t; cfg_src = s; cfg_pol = p;
        #1;
        chk(req, 32'(cfg_rdata), 32'(e));
    endtask

    // One run edge with per-requirement checks against the model.
    task automatic step(input logic [3:0] s);
        stream_i = s;
        @(posedge clk);
        @(negedge clk);
        exp_q = model(exp_q, s);
        chk("R6 full state", 32'(q_o), 32'(exp_q));
        chk("R7 empty cell", 32'(q_o[6]), 32'd0);
        chk("R9 shift row", 32'({q_o[11:8], q_o[3:0]}), 32'({exp_q[11:8], exp_q[3:0]}));
        chk("R10 match out", 32'({qn_o[4], q_o[4]}), 32'({!exp_q[4], exp_q[4]}));
        chk("R8 AND on qn", 32'(qn_o[5]), 32'(!exp_q[5]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; prog_en = 1'b1; cfg_we = 1'b0; cfg_tgt = '0; cfg_src = '0;
        cfg_pol = 1'b0; cfg_wdata = 1'b0; stream_i = 4'hF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset q", 32'(q_o), 32'd0);
        rst_n = 1'b1;
        rd(4'd0, 5'd16, 1'b0, 1'b0, "R1 reset store");

        // Program the map.
        wr(0, 16, 0, 1); wr(1, 0, 0, 1); wr(2, 1, 0, 1); wr(3, 2, 0, 1);
        wr(8, 18, 0, 1); wr(9, 8, 0, 1); wr(10, 9, 0, 1); wr(11, 10, 0, 1);
        wr(4, 0, 1, 1); wr(4, 1, 0, 1); wr(4, 3, 1, 1);
        wr(5, 8, 1, 1); wr(5, 9, 1, 1);
        wr(7, 17, 0, 1); wr(12, 12, 1, 1);
        rd(0, 16, 0, 1'b1, "R2 readback set");
        rd(0, 16, 1, 1'b0, "R2 polarity separate");
        wr(6, 0, 0, 1); rd(6, 0, 0, 1'b1, "R2 overwrite to 1");
        wr(6, 0, 0, 0); rd(6, 0, 0, 1'b0, "R2 overwrite to 0");
        wr(0, 25, 0, 1); rd(0, 25, 0, 1'b0, "R2 out of range");
        chk("R4 frozen while programming", 32'(q_o), 32'd0);

        // Leave program mode: first edge clears.
        prog_en = 1'b0; stream_i = 4'hF;
        @(posedge clk);
        @(negedge clk);
        exp_q = '0;
        chk("R5 clear on exit", 32'(q_o), 32'd0);

        for (int i = 0; i < 16; i++) step(STIM[i]);

        // Write attempt in run mode must be ignored.
        cfg_tgt = 4'd6; cfg_src = 5'd17; cfg_pol = 1'b0; cfg_wdata = 1'b1; cfg_we = 1'b1;
        step(4'h2);
        cfg_we = 1'b0;
        step(4'h2);
        chk("R3 run write no effect", 32'(q_o[6]), 32'd0);

        // Enter program mode with a non-zero state and stir the inputs.
        prog_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            stream_i = STIM[i];
            @(posedge clk);
            @(negedge clk);
            chk("R4 hold", 32'(q_o), 32'(exp_q));
        end
        rd(6, 17, 0, 1'b0, "R3 run write not stored");

        // Exit again: clear, then evaluation resumes.
        prog_en = 1'b0; stream_i = 4'hF;
        @(posedge clk);
        @(negedge clk);
        exp_q = '0;
        chk("R5 clear on second exit", 32'(q_o), 32'd0);
        for (int i = 0; i < 6; i++) step(STIM[15 - i]);

        // Reset mid-run wipes state and store.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset q mid-run", 32'(q_o), 32'd0);
        rst_n = 1'b1;
        rd(0, 16, 0, 1'b0, "R1 reset clears store");
        rd(12, 12, 1, 1'b0, "R1 reset clears store");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule